// File: doc/BRIEF.md
# Three-Slot Asymmetric Decode Steering

This block sits between instruction alignment and the micro-op queue of a decoder that has three slots of unequal capability. Each cycle it looks at up to three candidate instructions in program order, each tagged with the number of micro-ops it expands to. It decides how many candidates are decoded, which slot each one occupies, and how many micro-ops go to the queue. Slot 0 takes an instruction of 1 to `DIRECT_MAX` micro-ops. Slots 1 and 2 take only single-micro-op instructions. As a result, the group size depends on where the complex instructions fall.

An instruction longer than `DIRECT_MAX` micro-ops goes to an internal microcode sequencer. It may only start from slot 0, and it is consumed alone. The sequencer then emits up to `SEQ_RATE` micro-ops in each cycle the queue is ready, until the instruction's full count has been produced. Direct decode stays stalled while the sequencer is busy. When the queue is not ready, nothing is consumed and nothing is emitted.

Top module: `decode_steer`

## Requirements
- R1: After reset the sequencer is idle (`ucode_busy` low), and with no valid candidates every slot bit, `consumed` and `uop_emit` are zero.
- R2: Candidate 0, with a count in the range 1 to `DIRECT_MAX`, is placed in slot 0 (`slot_valid[0]`) whenever the sequencer is idle and `dq_ready` is high.
- R3: Slot 1 holds candidate 1 only if slot 0 is used and candidate 1 has a count of exactly 1. Slot 2 holds candidate 2 only if slot 1 is used and candidate 2 has a count of exactly 1. The first candidate that fails these conditions ends the group.
- R4: `consumed` equals the number of set `slot_valid` bits, or 1 on a microcode start.
- R5: In a direct-decode cycle, `uop_emit` equals candidate 0's count plus one for each used slot among slots 1 and 2. It never exceeds `DIRECT_MAX`+2.
- R6: When candidate 0 is valid with a count above `DIRECT_MAX`, the sequencer is idle and `dq_ready` is high:
  - `consumed` is 1.
  - No slot bit is set.
  - `uop_emit` is 0.
  - `ucode_busy` is high from the next cycle.
- R7: While busy with `dq_ready` high, the sequencer emits min(`SEQ_RATE`, remaining) micro-ops per cycle. `ucode_busy` falls after the cycle that emits the last of the instruction's count.
- R8: While `ucode_busy` is high, no slot bit is set and `consumed` is 0, whatever the candidates are.
- R9: With `dq_ready` low:
  - `consumed`, `slot_valid` and `uop_emit` are all zero.
  - An active sequencer keeps its remaining count and stays busy.
- R10: Candidate i's count is `cand_uops[i*UOP_W +: UOP_W]`. A candidate whose valid bit is low, or whose count is 0, is treated as absent and ends the group at its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 3 | Valid bit of each candidate, bit 0 oldest |
| cand_uops | input | 3*UOP_W | Micro-op count of each candidate, packed by index |
| dq_ready | input | 1 | Downstream micro-op queue can accept this cycle |
| slot_valid | output | 3 | Slot i holds candidate i this cycle |
| consumed | output | 2 | Number of candidates taken this cycle |
| uop_emit | output | EMIT_W | Micro-ops delivered to the queue this cycle |
| ucode_busy | output | 1 | Microcode sequencer owns the decoder |

## Verification
The bench builds the block with `UOP_W`=3, `DIRECT_MAX`=4 and `SEQ_RATE`=4. With 3-bit counts, every candidate count from 0 through 7 can be driven. This covers absent, single, multi and microcode instructions, including the 5-to-7 range, which takes exactly two sequencer cycles and so exercises both a full chunk and a partial final chunk. Every combination of ready, the three valid bits and the three counts is applied. Each microcode start is followed through one stalled cycle and then its whole emission.

// File: rtl/decode_steer.sv
module decode_steer #(
  parameter int UOP_W      = 5,
  parameter int DIRECT_MAX = 4,
  parameter int SEQ_RATE   = 4,
  localparam int MAXE      = (DIRECT_MAX + 2 > SEQ_RATE) ? DIRECT_MAX + 2 : SEQ_RATE,
  localparam int EMIT_W    = $clog2(MAXE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cand_valid,
  input  logic [3*UOP_W-1:0] cand_uops,
  input  logic               dq_ready,
  output logic [2:0]         slot_valid,
  output logic [1:0]         consumed,
  output logic [EMIT_W-1:0]  uop_emit,
  output logic               ucode_busy
);

  logic [UOP_W-1:0] cnt [3];
  logic [2:0]       present;

  for (genvar i = 0; i < 3; i++) begin : g_cand
    assign cnt[i]     = cand_uops[i*UOP_W +: UOP_W];
    assign present[i] = cand_valid[i] && (cnt[i] != '0);
  end

  logic [UOP_W-1:0] remain;
  logic [UOP_W-1:0] chunk;
  logic             go, head_micro, ucode_start;

  assign ucode_busy  = (remain != '0);
  assign chunk       = (remain > UOP_W'(SEQ_RATE)) ? UOP_W'(SEQ_RATE) : remain;
  assign go          = dq_ready && !ucode_busy;
  assign head_micro  = present[0] && (cnt[0] > UOP_W'(DIRECT_MAX));
  assign ucode_start = go && head_micro;

  assign slot_valid[0] = go && present[0] && !head_micro;
  assign slot_valid[1] = slot_valid[0] && present[1] && (cnt[1] == UOP_W'(1));
  assign slot_valid[2] = slot_valid[1] && present[2] && (cnt[2] == UOP_W'(1));

  assign consumed = ucode_start ? 2'd1
                  : 2'(slot_valid[0]) + 2'(slot_valid[1]) + 2'(slot_valid[2]);

  always_comb begin
    uop_emit = '0;
    if (ucode_busy) begin
      if (dq_ready) uop_emit = EMIT_W'(chunk);
    end else if (slot_valid[0]) begin
      uop_emit = EMIT_W'(cnt[0]) + EMIT_W'(slot_valid[1]) + EMIT_W'(slot_valid[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       remain <= '0;
    else if (ucode_start)             remain <= cnt[0];
    else if (ucode_busy && dq_ready)  remain <= remain - chunk;
  end

endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
  parameter int UOP_W      = 5,
  parameter int DIRECT_MAX = 4,
  parameter int SEQ_RATE   = 4,
  localparam int MAXE      = (DIRECT_MAX + 2 > SEQ_RATE) ? DIRECT_MAX + 2 : SEQ_RATE,
  localparam int EMIT_W    = $clog2(MAXE + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cand_valid,
  input logic [3*UOP_W-1:0] cand_uops,
  input logic               dq_ready,
  input logic [2:0]         slot_valid,
  input logic [1:0]         consumed,
  input logic [EMIT_W-1:0]  uop_emit,
  input logic               ucode_busy
);

  wire [UOP_W-1:0] c0 = cand_uops[0 +: UOP_W];
  wire [UOP_W-1:0] c1 = cand_uops[UOP_W +: UOP_W];
  wire [UOP_W-1:0] c2 = cand_uops[2*UOP_W +: UOP_W];

  assert_slot0_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[0] |-> (cand_valid[0] && c0 != '0 && c0 <= UOP_W'(DIRECT_MAX)));

  assert_slot_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid[1] |-> (c1 == UOP_W'(1) && slot_valid[0])) and
    (slot_valid[2] |-> (c2 == UOP_W'(1) && slot_valid[1])));

  assert_emit_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ucode_busy |-> (uop_emit <= EMIT_W'(DIRECT_MAX + 2)));

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucode_busy && dq_ready && cand_valid[0] && c0 > UOP_W'(DIRECT_MAX)) |=> ucode_busy);

  assert_seq_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ucode_busy && dq_ready && uop_emit < EMIT_W'(SEQ_RATE)) |=> !ucode_busy);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_busy |-> (slot_valid == 3'b000 && consumed == 2'd0));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_ready |-> (consumed == 2'd0 && uop_emit == '0 && slot_valid == 3'b000));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ucode_busy && !dq_ready) |=> ucode_busy);

endmodule

bind decode_steer decode_steer_chk #(
  .UOP_W(UOP_W), .DIRECT_MAX(DIRECT_MAX), .SEQ_RATE(SEQ_RATE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_uops(cand_uops),
  .dq_ready(dq_ready), .slot_valid(slot_valid), .consumed(consumed),
  .uop_emit(uop_emit), .ucode_busy(ucode_busy)
);

// File: tb/decode_steer_tb_top.sv
module decode_steer_tb_top;
  localparam int UW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cand_valid;
  logic [3*UW-1:0] cand_uops;
  logic          dq_ready;
  logic [2:0]    slot_valid;
  logic [1:0]    consumed;
  logic [2:0]    uop_emit;
  logic          ucode_busy;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #4 clk = ~clk;

  decode_steer #(.UOP_W(UW), .DIRECT_MAX(4), .SEQ_RATE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_uops(cand_uops),
    .dq_ready(dq_ready), .slot_valid(slot_valid), .consumed(consumed),
    .uop_emit(uop_emit), .ucode_busy(ucode_busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    cand_valid = '0; cand_uops = '0; dq_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 busy after reset", int'(ucode_busy), 0);
    chk("R1 slots after reset", int'(slot_valid), 0);
    chk("R1 emit after reset", int'(uop_emit), 0);
    chk("R1 consumed after reset", int'(consumed), 0);

    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 8; v++)
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++)
            for (int c = 0; c < 8; c++) begin
              bit p0, micro, e0, e1, e2;
              int ec, ee, rem;
              @(negedge clk);
              cand_valid = 3'(v);
              cand_uops  = {3'(c), 3'(b), 3'(a)};
              dq_ready   = r[0];
              #1;
              p0    = v[0] && a != 0;
              micro = p0 && a > 4;
              e0    = r[0] && p0 && !micro;
              e1    = e0 && v[1] && b == 1;
              e2    = e1 && v[2] && c == 1;
              ec    = (r[0] && micro) ? 1 : int'(e0) + int'(e1) + int'(e2);
              ee    = e0 ? a + int'(e1) + int'(e2) : 0;
              if (r == 0) begin
                chk("R9 stalled slots", int'(slot_valid), 0);
                chk("R9 stalled consumed", int'(consumed), 0);
                chk("R9 stalled emit", int'(uop_emit), 0);
              end else begin
                chk("R2 R3 R10 slot map", int'(slot_valid), int'({e2, e1, e0}));
                chk("R4 R6 consumed", int'(consumed), ec);
                chk("R5 R6 emit", int'(uop_emit), ee);
              end
              chk("R8 idle between groups", int'(ucode_busy), 0);
              if (r == 1 && micro) begin
                @(negedge clk);
                dq_ready = 1'b0;
                #1;
                chk("R6 busy after start", int'(ucode_busy), 1);
                chk("R9 sequencer stalled emit", int'(uop_emit), 0);
                chk("R8 no slots while busy", int'(slot_valid), 0);
                @(negedge clk);
                dq_ready = 1'b1;
                #1;
                chk("R9 busy held through stall", int'(ucode_busy), 1);
                rem = a;
                while (rem > 0) begin
                  int chunk;
                  chunk = rem > 4 ? 4 : rem;
                  chk("R8 busy during emission", int'(ucode_busy), 1);
                  chk("R8 no consume while busy", int'(consumed), 0);
                  chk("R8 no slots while busy", int'(slot_valid), 0);
                  chk("R7 sequencer chunk", int'(uop_emit), chunk);
                  rem -= chunk;
                  @(negedge clk); #1;
                end
                chk("R7 busy falls after last chunk", int'(ucode_busy), 0);
                dq_ready = 1'b0;
              end
            end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule